// File: doc/BRIEF.md
# Interpolating Sine Oscillator

This block is a numerically controlled oscillator. A phase accumulator of `ACC_W` bits advances by a programmable tuning word on every clock and wraps modulo 2^ACC_W. A phase offset is added to the accumulator value on the way to the waveform stage only. The summed phase is split into three fields. The top two bits are the quadrant. The next `Q_W` bits index a quarter-wave amplitude table. The remaining `FRAC_W = ACC_W-2-Q_W` bits are kept as an interpolation fraction rather than dropped. The result is a signed sample with a valid strobe.

In the second and fourth quadrants the table is read mirrored, and in the lower half-wave the sample is negated. Linear interpolation between neighbouring table entries lets a small table give near full-resolution amplitude. Two flags describe the loaded tuning word. One says whether its fractional bits are all zero, so that no phase truncation ever occurs. The other says whether it is a power of two, so that every output cycle is bit-identical.

Top module: `dds_sine_gen`

## Requirements
- R1: After reset the accumulator and tuning word are 0. On every rising clock edge the accumulator becomes (accumulator + tuning word) mod 2^ACC_W, including when it wraps past zero in either direction.
- R2: A word presented with `tune_load_i` high is captured on that edge and first advances the accumulator on the next edge. Loading never resets or steps the accumulator, so phase is continuous across a change of word.
- R3: The lookup phase is (accumulator + `phase_off_i`) mod 2^ACC_W, sampled on the same edge. The offset is never accumulated: removing it returns the output to the un-offset phase at once.
- R4: `valid_o` is 0 during reset and for the first two rising edges after reset release. It is 1 from the third edge on and stays 1. The sample present after edge e belongs to the lookup phase sampled at edge e-2.
- R5: For lookup phase p the sample is within 2 LSB of AMP·sin(2πp/2^ACC_W), where AMP = 2^(OUT_W-1)-1.
- R6: Half-wave antisymmetry is exact: sample(p + 2^(ACC_W-1)) = -sample(p).
- R7: Quarter mirroring is exact: sample(2^(ACC_W-1) - p) = sample(p) for 0 ≤ p ≤ 2^(ACC_W-2).
- R8: Phase 0 gives 0, phase 2^(ACC_W-2) gives +AMP, and phase 3·2^(ACC_W-2) gives -AMP.
- R9: `exact_phase_o` is 1 exactly when the low FRAC_W bits of the current tuning word are all zero. It is 1 after reset.
- R10: `periodic_o` is 1 exactly when the current tuning word is a nonzero power of two. It is 0 after reset.
- R11: Within the first quadrant the sample never decreases as phase increases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tune_load_i | input | 1 | Capture `tune_word_i` on this edge |
| tune_word_i | input | ACC_W | Phase step per clock |
| phase_off_i | input | ACC_W | Phase offset added before lookup |
| sample_o | output | OUT_W | Signed sine sample |
| valid_o | output | 1 | Sample pipeline filled |
| exact_phase_o | output | 1 | Current word has zero fractional bits |
| periodic_o | output | 1 | Current word is a power of two |

## Verification
A corrupted accumulator or tuning register puts the wrong phase into the lookup. That shows at `sample_o` two edges after the faulty phase is sampled, and the error persists because the accumulator carries it forward. A wrong fold, negation or table address breaks the exact symmetry relations between samples of mirrored phases. A wrong interpolation breaks accuracy or monotonicity between table points. Flag faults appear on the edge right after a load.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;

  localparam longint HALF_PI_Q30 = 64'sd1686629713;

  // sin(k/2^qw * pi/2) in Q30, odd Taylor series to x^11
  function automatic longint sin_q30(input longint k, input int qw);
    longint th, t2, term, acc;
    th   = (HALF_PI_Q30 * k) >>> qw;
    t2   = (th * th) >>> 30;
    term = th;
    acc  = th;
    for (int i = 1; i <= 5; i++) begin
      term = -(((term * t2) >>> 30) / longint'((2 * i) * (2 * i + 1)));
      acc  = acc + term;
    end
    return acc;
  endfunction

  function automatic int sine_code(input int k, input int qw, input int ow);
    longint amp;
    amp = (64'sd1 << (ow - 1)) - 64'sd1;
    return int'((sin_q30(longint'(k), qw) * amp + (64'sd1 <<< 29)) >>> 30);
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
`timescale 1ns/1ps
module dds_phase_acc #(
  parameter int ACC_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ACC_W-1:0] word_i,
  input  logic [ACC_W-1:0] offset_i,
  output logic [ACC_W-1:0] phase_o,
  output logic             exact_o,
  output logic             period_o
);

  logic [ACC_W-1:0] tune_q, acc_q, phase_q;
  logic             exact_q, period_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tune_q   <= '0;
      acc_q    <= '0;
      phase_q  <= '0;
      exact_q  <= 1'b1;
      period_q <= 1'b0;
    end else begin
      acc_q   <= acc_q + tune_q;
      phase_q <= acc_q + offset_i;
      if (load_i) begin
        tune_q   <= word_i;
        exact_q  <= (word_i[FRAC_W-1:0] == '0);
        period_q <= (word_i != '0) && ((word_i & (word_i - ACC_W'(1))) == '0);
      end
    end
  end

  assign phase_o  = phase_q;
  assign exact_o  = exact_q;
  assign period_o = period_q;

  AST_TUNE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> $stable(tune_q)); // R2
  AST_EXACT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exact_q == (tune_q[FRAC_W-1:0] == '0)); // R9
  AST_PERIOD_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_q == ($countones(tune_q) == 1)); // R10

endmodule

// File: rtl/dds_quarter_lut.sv
`timescale 1ns/1ps
module dds_quarter_lut #(
  parameter int ACC_W = 16,
  parameter int Q_W   = 8,
  parameter int OUT_W = 12
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ACC_W-1:0]            phase_i,
  output logic [OUT_W-1:0]            y0_o,
  output logic [OUT_W-1:0]            y1_o,
  output logic [ACC_W-Q_W-3:0]        frac_o,
  output logic                        neg_o
);

  localparam int P_W    = ACC_W - 2;
  localparam int FRAC_W = P_W - Q_W;
  localparam int DEPTH  = (1 << Q_W) + 1;

  logic [OUT_W-1:0] rom [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    assign rom[k] = OUT_W'(dds_pkg::sine_code(k, Q_W, OUT_W));
  end

  logic [P_W:0] fold;
  logic [Q_W:0] idx0, idx1;

  always_comb begin
    // odd quadrants read the table backwards: 2^P_W - u
    if (phase_i[ACC_W-2]) fold = ((P_W+1)'(1) << P_W) - {1'b0, phase_i[P_W-1:0]};
    else                  fold = {1'b0, phase_i[P_W-1:0]};
    idx0 = fold[P_W:FRAC_W];
    idx1 = (idx0 == (Q_W+1)'(DEPTH - 1)) ? idx0 : idx0 + (Q_W+1)'(1);
  end

  logic [OUT_W-1:0]  y0_q, y1_q;
  logic [FRAC_W-1:0] frac_q;
  logic              neg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y0_q   <= '0;
      y1_q   <= '0;
      frac_q <= '0;
      neg_q  <= 1'b0;
    end else begin
      y0_q   <= rom[idx0];
      y1_q   <= rom[idx1];
      frac_q <= fold[FRAC_W-1:0];
      neg_q  <= phase_i[ACC_W-1];
    end
  end

  assign y0_o   = y0_q;
  assign y1_o   = y1_q;
  assign frac_o = frac_q;
  assign neg_o  = neg_q;

  AST_TABLE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y0_q <= y1_q); // R11

endmodule

// File: rtl/dds_interp.sv
`timescale 1ns/1ps
module dds_interp #(
  parameter int OUT_W  = 12,
  parameter int FRAC_W = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [OUT_W-1:0]        y0_i,
  input  logic [OUT_W-1:0]        y1_i,
  input  logic [FRAC_W-1:0]       frac_i,
  input  logic                    neg_i,
  output logic signed [OUT_W-1:0] sample_o
);

  localparam int D_W = OUT_W + FRAC_W + 2;
  localparam int AMP = (1 << (OUT_W - 1)) - 1;
  localparam logic signed [D_W-1:0] RND = D_W'(1 << (FRAC_W - 1));

  logic signed [D_W-1:0] diff, prod, mag;
  logic signed [OUT_W-1:0] mag_n, sample_d, sample_q;

  always_comb begin
    diff     = signed'(D_W'(y1_i)) - signed'(D_W'(y0_i));
    prod     = diff * signed'(D_W'(frac_i));
    mag      = signed'(D_W'(y0_i)) + ((prod + RND) >>> FRAC_W);
    mag_n    = mag[OUT_W-1:0];
    sample_d = neg_i ? -mag_n : mag_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_q <= '0;
    else         sample_q <= sample_d;
  end

  assign sample_o = sample_q;

  AST_SAMPLE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_q <= AMP) && (sample_q >= -AMP)); // R5

endmodule

// File: rtl/dds_sine_gen.sv
`timescale 1ns/1ps
module dds_sine_gen #(
  parameter int ACC_W = 16,
  parameter int Q_W   = 8,
  parameter int OUT_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tune_load_i,
  input  logic [ACC_W-1:0]        tune_word_i,
  input  logic [ACC_W-1:0]        phase_off_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    valid_o,
  output logic                    exact_phase_o,
  output logic                    periodic_o
);

  localparam int FRAC_W = ACC_W - 2 - Q_W;
  localparam int LAT    = 3;

  logic [ACC_W-1:0]  phase;
  logic [OUT_W-1:0]  y0, y1;
  logic [FRAC_W-1:0] frac;
  logic              neg;
  logic [LAT-1:0]    vld_q;

  dds_phase_acc #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) i_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tune_load_i),
    .word_i  (tune_word_i),
    .offset_i(phase_off_i),
    .phase_o (phase),
    .exact_o (exact_phase_o),
    .period_o(periodic_o)
  );

  dds_quarter_lut #(.ACC_W(ACC_W), .Q_W(Q_W), .OUT_W(OUT_W)) i_lut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_i(phase),
    .y0_o   (y0),
    .y1_o   (y1),
    .frac_o (frac),
    .neg_o  (neg)
  );

  dds_interp #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) i_interp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .y0_i    (y0),
    .y1_i    (y1),
    .frac_i  (frac),
    .neg_i   (neg),
    .sample_o(sample_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LAT-2:0], 1'b1};
  end

  assign valid_o = vld_q[LAT-1];

  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o); // R4
  AST_ZERO_UNTIL_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (sample_o == '0)); // R4

endmodule

// File: tb/test_dds_sine_gen.sv
`timescale 1ns/1ps
module test_dds_sine_gen;

  localparam int AW  = 12;
  localparam int QW  = 5;
  localparam int OW  = 10;
  localparam int FW  = AW - 2 - QW;
  localparam int NPH = 1 << AW;
  localparam int AMP = (1 << (OW - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [AW-1:0] word = '0;
  logic [AW-1:0] off = '0;
  logic signed [OW-1:0] sample;
  logic valid, exact, periodic;

  int n_run = 0;
  int n_fail = 0;
  int mdl_acc = 0;
  int mdl_tune = 0;
  int hcnt = 0;
  int hist [4];
  int samp [NPH];
  bit seen [NPH];

  always #2.5 clk = ~clk;

  dds_sine_gen #(.ACC_W(AW), .Q_W(QW), .OUT_W(OW)) i_dds_sine_gen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tune_load_i  (load),
    .tune_word_i  (word),
    .phase_off_i  (off),
    .sample_o     (sample),
    .valid_o      (valid),
    .exact_phase_o(exact),
    .periodic_o   (periodic)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: model the lookup phase sampled at the coming edge, then check outputs
  task automatic tick(input string tag);
    real r;
    int p, act;
    hist[(hcnt + 1) % 4] = (mdl_acc + int'(off)) % NPH;
    mdl_acc = (mdl_acc + mdl_tune) % NPH;
    if (load) mdl_tune = int'(word);
    @(posedge clk);
    hcnt++;
    @(negedge clk);
    check(valid == (hcnt >= 3), "R4 valid timing", int'(valid), int'(hcnt >= 3));
    if (hcnt >= 3) begin
      p   = hist[(hcnt - 2) % 4];
      act = int'(sample);
      r   = AMP * $sin(6.283185307179586 * p / NPH);
      check((act - r < 2.0) && (r - act < 2.0), {tag, " R5 sample vs sine"}, act, $rtoi(r));
      samp[p] = act;
      seen[p] = 1'b1;
    end
  endtask

  task automatic load_word(input int w, input string tag);
    bit e, pw;
    word = AW'(w);
    load = 1'b1;
    tick(tag);
    load = 1'b0;
    e  = (w % (1 << FW)) == 0;
    pw = (w != 0) && ((w & (w - 1)) == 0);
    check(exact == e, "R9 exact flag", int'(exact), int'(e));
    check(periodic == pw, "R10 periodic flag", int'(periodic), int'(pw));
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(valid == 1'b0, "R4 valid in reset", int'(valid), 0);
    check(sample == '0, "R1 sample in reset", int'(sample), 0);
    check(exact == 1'b1, "R9 exact in reset", int'(exact), 1);
    check(periodic == 1'b0, "R10 periodic in reset", int'(periodic), 0);
    rst_n = 1'b1;

    // full sweep, step 1, crosses the wrap
    load_word(1, "R2");
    run(NPH + 8, "R1");
    begin
      int miss = 0;
      for (int p = 0; p < NPH; p++) if (!seen[p]) miss++;
      check(miss == 0, "R1 sweep covers all phases", miss, 0);
    end
    for (int p = 0; p < NPH / 2; p++)
      check(samp[p + NPH / 2] == -samp[p], "R6 half-wave antisymmetry", samp[p + NPH / 2], -samp[p]);
    for (int p = 0; p <= NPH / 4; p++)
      check(samp[NPH / 2 - p] == samp[p], "R7 quarter mirror", samp[NPH / 2 - p], samp[p]);
    for (int p = 0; p < NPH / 4; p++)
      check(samp[p + 1] >= samp[p], "R11 first-quadrant monotonic", samp[p + 1], samp[p]);
    check(samp[0] == 0, "R8 zero phase", samp[0], 0);
    check(samp[NPH / 4] == AMP, "R8 positive peak", samp[NPH / 4], AMP);
    check(samp[3 * NPH / 4] == -AMP, "R8 negative peak", samp[3 * NPH / 4], -AMP);

    // word changes without pause: phase must continue
    load_word(12'h0C0, "R2");
    run(300, "R2");
    load_word(12'h400, "R2");
    run(20, "R2");
    load_word(12'hFFD, "R1");
    run(300, "R1");
    load_word(12'h123, "R2");
    run(200, "R2");

    // offset only shifts the lookup
    load_word(12'h0C0, "R3");
    off = 12'h155;
    run(200, "R3");
    off = 12'h0;
    run(50, "R3");
    off = 12'hA01;
    run(40, "R3");
    off = 12'h0;

    // zero step holds phase
    load_word(0, "R2");
    run(20, "R2");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule